// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends one command byte, and an argument byte where the command takes one, from the host to a PS/2 keyboard. Both bus lines are open-collector. The block never drives a line high. It only pulls a line toward ground through an active-low hold output, and the two-wire bus is the wired-AND of its holds and the device's own drivers.

A transfer has four phases:

- **Inhibit.** The block pulls the clock low for a programmable number of cycles, which stops the device from sending.
- **Request to send.** The block releases the clock and pulls data low.
- **Shifting.** The device now generates the clock. On each falling edge the block presents the next frame bit: eight data bits LSB first, then odd parity, then a released stop bit.
- **Acknowledge.** After the stop bit the block checks that the device pulls data low, and then waits for both lines to return high.

The lock-LED command (0xED) and the typematic-rate command (0xF3) each carry an argument byte. For these, the block waits after the first byte for the acknowledge byte 0xFA. A separate receiver delivers that byte on `rx_valid`/`rx_byte`, and only then does the block send the argument through a second full transfer. Echo (0xEE), resend (0xFE) and reset (0xFF) are single-byte commands.

A command is started with a one-cycle `start` while `busy` is low. Every command ends with a one-cycle `done` pulse, which carries an outcome code on `err_kind`.

Top module: `ps2_cmd_tx`

## Requirements
- R1: After reset, and whenever `busy` is low, both hold outputs are 1 (lines released), `busy` is 0 and `done` is 0 until a command ends.
- R2: A `start` with a supported code while idle raises `busy` and pulls the clock (hold low) for exactly INHIBIT_CYC cycles; the data line stays released during this time.
- R3: When the inhibit ends, the clock is released and data is pulled low in the same cycle, and the two lines are never pulled at the same time.
- R4: On each device clock falling edge, the block presents the next bit of the frame. Falling edges 1 to 8 carry the data bits LSB first, edge 9 the odd parity bit (the nine bits hold an odd number of ones), and edge 10 a released stop bit (1).
- R5: `done` is a one-cycle pulse that coincides with `busy` falling. `err_kind` gives the outcome: 0 success, 1 no acknowledge bit, 2 timeout, 3 wrong reply byte, 4 unsupported code. `error` is high exactly with a `done` whose `err_kind` is nonzero.
- R6: At the 11th falling edge the block samples data. If data is low, the transfer succeeds once both lines are high again. If data is high, the command ends with `err_kind` 1 and nothing further is sent.
- R7: Codes 0xEE, 0xFE and 0xFF send one byte and end with `err_kind` 0 after a good acknowledge bit.
- R8: Codes 0xED and 0xF3 keep `busy` high after the first byte until `rx_valid`. If `rx_byte` is 0xFA, the argument byte is then sent as a second full transfer, inhibit included. Any other byte ends the command with `err_kind` 3, and the argument is never sent.
- R9: If TIMEOUT_CYC cycles pass with no progress, the command ends with `err_kind` 2 and both lines released. "No progress" means no device falling edge while shifting, no idle bus while waiting for release, and no reply while waiting for one.
- R10: A code outside {0xED, 0xEE, 0xF3, 0xFE, 0xFF} produces `done` with `err_kind` 4 on the next cycle, and neither line is pulled.
- R11: A `start` while `busy` is high is ignored. The byte on the wire is the one accepted first, and only one `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (taken only while idle) |
| cmd_code | input | 8 | Command byte |
| cmd_arg | input | 8 | Argument byte for 0xED / 0xF3 |
| rx_valid | input | 1 | Byte received from the device is valid |
| rx_byte | input | 8 | Byte received from the device |
| ps2_clk_in | input | 1 | Sensed PS/2 clock line |
| ps2_dat_in | input | 1 | Sensed PS/2 data line |
| ps2_clk_hold_n | output | 1 | 0 pulls the clock line low |
| ps2_dat_hold_n | output | 1 | 0 pulls the data line low |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| error | output | 1 | The ending command failed |
| err_kind | output | 3 | Outcome code of the most recent command |

## Verification
The assertions watch four invariants on every cycle:

- both lines are released while idle;
- the clock hold lasts at least the inhibit length;
- the two lines are never pulled together;
- `done`, `error` and the fall of `busy` stay aligned.

Other behaviour depends on a device actually responding, and only the bench scenarios can show it. This covers the bit order and parity a device samples on its rising edges, and the acknowledge-bit decision. It also covers the gating of the argument byte on the reply value, the timeout when the device stays silent, and the rejection of bad codes and of starts issued while busy.

// File: rtl/ps2_cmd_tx.sv
module ps2_cmd_tx #(
  parameter int INHIBIT_CYC = 5000,
  parameter int TIMEOUT_CYC = 750000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] cmd_code,
  input  logic [7:0] cmd_arg,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       ps2_clk_in,
  input  logic       ps2_dat_in,
  output logic       ps2_clk_hold_n,
  output logic       ps2_dat_hold_n,
  output logic       busy,
  output logic       done,
  output logic       error,
  output logic [2:0] err_kind
);

  localparam int TMAX = (INHIBIT_CYC > TIMEOUT_CYC) ? INHIBIT_CYC : TIMEOUT_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  localparam logic [7:0] CMD_LEDS   = 8'hED;
  localparam logic [7:0] CMD_ECHO   = 8'hEE;
  localparam logic [7:0] CMD_RATE   = 8'hF3;
  localparam logic [7:0] CMD_RESEND = 8'hFE;
  localparam logic [7:0] CMD_RESET  = 8'hFF;
  localparam logic [7:0] REPLY_OK   = 8'hFA;

  localparam logic [2:0] K_NONE  = 3'd0;
  localparam logic [2:0] K_NACK  = 3'd1;
  localparam logic [2:0] K_TMO   = 3'd2;
  localparam logic [2:0] K_REPLY = 3'd3;
  localparam logic [2:0] K_CODE  = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_INH, S_XFER, S_LINE, S_REPLY} st_t;

  st_t         state;
  logic [TW-1:0] timer;
  logic [3:0]  bitn;
  logic [8:0]  shreg;
  logic [7:0]  arg_q;
  logic        tx_bit, has_arg, second;
  logic [2:0]  kind;
  logic [2:0]  cs;
  logic [1:0]  ds;

  wire fall      = cs[2] & ~cs[1];
  wire line_clk  = cs[1];
  wire line_dat  = ds[1];
  wire inh_end   = (timer == TW'(INHIBIT_CYC - 1));
  wire tmo       = (timer == TW'(TIMEOUT_CYC - 1));
  wire supported = (cmd_code == CMD_LEDS) || (cmd_code == CMD_ECHO) ||
                   (cmd_code == CMD_RATE) || (cmd_code == CMD_RESEND) ||
                   (cmd_code == CMD_RESET);
  wire needs_arg = (cmd_code == CMD_LEDS) || (cmd_code == CMD_RATE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs <= 3'b111;
      ds <= 2'b11;
    end else begin
      cs <= {cs[1:0], ps2_clk_in};
      ds <= {ds[0], ps2_dat_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      timer   <= '0;
      bitn    <= '0;
      shreg   <= '0;
      arg_q   <= '0;
      tx_bit  <= 1'b1;
      has_arg <= 1'b0;
      second  <= 1'b0;
      kind    <= K_NONE;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          tx_bit <= 1'b1;
          if (start) begin
            if (supported) begin
              shreg   <= {~^cmd_code, cmd_code};
              arg_q   <= cmd_arg;
              has_arg <= needs_arg;
              second  <= 1'b0;
              timer   <= '0;
              state   <= S_INH;
            end else begin
              done <= 1'b1;
              kind <= K_CODE;
            end
          end
        end
        S_INH: begin
          if (inh_end) begin
            state  <= S_XFER;
            timer  <= '0;
            bitn   <= '0;
            tx_bit <= 1'b0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        S_XFER: begin
          if (fall) begin
            timer <= '0;
            bitn  <= bitn + 1'b1;
            if (bitn < 4'd9) begin
              tx_bit <= shreg[0];
              shreg  <= {1'b1, shreg[8:1]};
            end else if (bitn == 4'd9) begin
              tx_bit <= 1'b1;
            end else begin
              tx_bit <= 1'b1;
              if (!line_dat) begin
                state <= S_LINE;
              end else begin
                state <= S_IDLE;
                done  <= 1'b1;
                kind  <= K_NACK;
              end
            end
          end else if (tmo) begin
            state  <= S_IDLE;
            tx_bit <= 1'b1;
            done   <= 1'b1;
            kind   <= K_TMO;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        S_LINE: begin
          if (line_clk && line_dat) begin
            timer <= '0;
            if (has_arg && !second) begin
              state <= S_REPLY;
            end else begin
              state <= S_IDLE;
              done  <= 1'b1;
              kind  <= K_NONE;
            end
          end else if (tmo) begin
            state <= S_IDLE;
            done  <= 1'b1;
            kind  <= K_TMO;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        S_REPLY: begin
          if (rx_valid) begin
            if (rx_byte == REPLY_OK) begin
              second <= 1'b1;
              shreg  <= {~^arg_q, arg_q};
              timer  <= '0;
              state  <= S_INH;
            end else begin
              state <= S_IDLE;
              done  <= 1'b1;
              kind  <= K_REPLY;
            end
          end else if (tmo) begin
            state <= S_IDLE;
            done  <= 1'b1;
            kind  <= K_TMO;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy           = (state != S_IDLE);
  assign ps2_clk_hold_n = ~(state == S_INH);
  assign ps2_dat_hold_n = ~((state == S_XFER) && !tx_bit);
  assign error          = done && (kind != K_NONE);
  assign err_kind       = kind;

endmodule

// File: rtl/ps2_cmd_tx_chk.sv
module ps2_cmd_tx_chk #(
  parameter int INHIBIT_CYC = 5000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ps2_clk_hold_n,
  input logic       ps2_dat_hold_n,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic [2:0] err_kind
);

  logic [31:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n) low_run <= '0;
    else if (!ps2_clk_hold_n) low_run <= low_run + 1;
    else low_run <= '0;
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ps2_clk_hold_n && ps2_dat_hold_n)); // R1

  AST_INHIBIT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ps2_clk_hold_n) |-> (low_run >= 32'(INHIBIT_CYC))); // R2

  AST_ONE_LINE_PULLED: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ps2_clk_hold_n && !ps2_dat_hold_n)); // R3

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R5

  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R5

  AST_ERROR_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (done && err_kind != 3'd0)); // R5

endmodule

bind ps2_cmd_tx ps2_cmd_tx_chk #(.INHIBIT_CYC(INHIBIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ps2_clk_hold_n(ps2_clk_hold_n), .ps2_dat_hold_n(ps2_dat_hold_n),
  .busy(busy), .done(done), .error(error), .err_kind(err_kind)
);

// File: tb/tb_ps2_cmd_tx.sv
module tb_ps2_cmd_tx;
  localparam int INH = 40;
  localparam int TMO = 1500;
  localparam int H   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] cmd_code = '0, cmd_arg = '0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic dev_clk = 1'b1, dev_dat = 1'b1;
  logic ps2_clk_in, ps2_dat_in;
  logic ps2_clk_hold_n, ps2_dat_hold_n, busy, done, error;
  logic [2:0] err_kind;

  always #2.5 clk = ~clk;

  assign ps2_clk_in = ps2_clk_hold_n & dev_clk;
  assign ps2_dat_in = ps2_dat_hold_n & dev_dat;

  ps2_cmd_tx #(.INHIBIT_CYC(INH), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_code(cmd_code), .cmd_arg(cmd_arg),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .ps2_clk_in(ps2_clk_in), .ps2_dat_in(ps2_dat_in),
    .ps2_clk_hold_n(ps2_clk_hold_n), .ps2_dat_hold_n(ps2_dat_hold_n),
    .busy(busy), .done(done), .error(error), .err_kind(err_kind));

  int checks = 0, errors = 0;
  int done_cnt = 0, clk_low_cnt = 0;
  logic [2:0] last_kind = '0;
  logic last_err = 1'b0;
  bit finished = 0;

  always @(posedge clk) begin
    if (done) begin
      done_cnt  <= done_cnt + 1;
      last_kind <= err_kind;
      last_err  <= error;
    end
    if (!ps2_clk_hold_n) clk_low_cnt <= clk_low_cnt + 1;
  end

  // code, arg, device mode (0 ack, 1 no ack), reply, expected kind, bytes on wire
  localparam logic [30:0] VEC [8] = '{
    {8'hEE, 8'h00, 2'd0, 8'h00, 3'd0, 2'd1},
    {8'hFF, 8'h00, 2'd0, 8'h00, 3'd0, 2'd1},
    {8'hFE, 8'h00, 2'd0, 8'h00, 3'd0, 2'd1},
    {8'hED, 8'h05, 2'd0, 8'hFA, 3'd0, 2'd2},
    {8'hF3, 8'h2B, 2'd0, 8'hFA, 3'd0, 2'd2},
    {8'hED, 8'h07, 2'd0, 8'hFE, 3'd3, 2'd1},
    {8'hEE, 8'h00, 2'd1, 8'h00, 3'd1, 2'd1},
    {8'hF3, 8'h7F, 2'd1, 8'h00, 3'd1, 2'd1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] c, input logic [7:0] a);
    @(negedge clk); start = 1'b1; cmd_code = c; cmd_arg = a;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic dev_xfer(input bit ack, output logic [7:0] b, output bit ok,
                          output int inh, output bit rts);
    logic [10:0] fr;
    inh = 0;
    while (ps2_clk_hold_n) @(negedge clk);
    while (!ps2_clk_hold_n) begin inh++; @(negedge clk); end
    rts = !ps2_dat_hold_n;
    repeat (4) @(negedge clk);
    for (int k = 1; k <= 11; k++) begin
      if (k == 11 && ack) dev_dat = 1'b0;
      dev_clk = 1'b0; repeat (H) @(negedge clk);
      dev_clk = 1'b1; fr[k-1] = ps2_dat_in; repeat (H) @(negedge clk);
    end
    dev_dat = 1'b1;
    b  = fr[7:0];
    ok = (^fr[8:0]) && fr[9];
  endtask

  task automatic wait_done(input int base, input int lim, output bit got);
    got = 0;
    for (int n = 0; n < lim && !got; n++) begin
      @(negedge clk);
      if (done_cnt != base) got = 1;
    end
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    bit ok, rts, got;
    int inh, base, lows;
    repeat (5) @(negedge clk);
    chk(ps2_clk_hold_n && ps2_dat_hold_n, "R1 lines released in reset", {ps2_clk_hold_n, ps2_dat_hold_n}, 3);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", {busy, done}, 0);
    chk(ps2_clk_hold_n && ps2_dat_hold_n, "R1 lines released idle", {ps2_clk_hold_n, ps2_dat_hold_n}, 3);

    for (int i = 0; i < 8; i++) begin
      logic [30:0] v;
      v = VEC[i];
      base = done_cnt;
      issue(v[30:23], v[22:15]);
      chk(busy, "R2 busy after start", busy, 1);
      dev_xfer(v[14:13] == 2'd0, b, ok, inh, rts);
      chk(inh == INH, "R2 inhibit length", inh, INH);
      chk(rts, "R3 data pulled after inhibit", rts, 1);
      chk(b == v[30:23], "R4 command byte on wire", b, v[30:23]);
      chk(ok, "R4 parity and stop", ok, 1);
      if (v[1:0] == 2'd2 || (v[4:2] == 3'd3)) begin
        repeat (20) @(negedge clk);
        chk(busy && done_cnt == base, "R8 waits for reply", busy, 1);
        @(negedge clk); rx_valid = 1'b1; rx_byte = v[12:5];
        @(negedge clk); rx_valid = 1'b0;
        if (v[12:5] == 8'hFA) begin
          dev_xfer(1'b1, b, ok, inh, rts);
          chk(b == v[22:15], "R8 argument byte on wire", b, v[22:15]);
          chk(ok && inh == INH, "R8 argument frame and inhibit", inh, INH);
        end
      end
      wait_done(base, TMO + 200, got);
      chk(got, "R5 done reached", got, 1);
      chk(last_kind == v[4:2], (v[4:2] == 3'd1) ? "R6 no-ack kind" :
          (v[4:2] == 3'd3) ? "R8 bad reply kind" : "R7 success kind", last_kind, v[4:2]);
      chk(last_err == (v[4:2] != 3'd0), "R5 error flag", last_err, v[4:2] != 3'd0);
      lows = clk_low_cnt;
      repeat (100) @(negedge clk);
      chk(clk_low_cnt == lows && !busy, "R6 R8 nothing further sent", clk_low_cnt - lows, 0);
      chk(done_cnt == base + 1, "R5 single done", done_cnt - base, 1);
    end

    // start while busy is ignored
    base = done_cnt;
    issue(8'hEE, 8'h00);
    repeat (5) @(negedge clk);
    issue(8'hFF, 8'h00);
    dev_xfer(1'b1, b, ok, inh, rts);
    chk(b == 8'hEE, "R11 first byte kept", b, 8'hEE);
    wait_done(base, 200, got);
    repeat (150) @(negedge clk);
    chk(done_cnt == base + 1, "R11 one done only", done_cnt - base, 1);

    // silent device
    base = done_cnt;
    issue(8'hEE, 8'h00);
    wait_done(base, TMO + INH + 100, got);
    chk(got && last_kind == 3'd2, "R9 timeout kind", last_kind, 2);
    chk(ps2_clk_hold_n && ps2_dat_hold_n && !busy, "R9 lines released", {ps2_clk_hold_n, ps2_dat_hold_n}, 3);

    // unsupported code
    base = done_cnt;
    lows = clk_low_cnt;
    issue(8'h12, 8'h00);
    wait_done(base, 10, got);
    chk(got && last_kind == 3'd4 && last_err, "R10 bad code kind", last_kind, 4);
    repeat (60) @(negedge clk);
    chk(clk_low_cnt == lows && ps2_dat_hold_n, "R10 lines untouched", clk_low_cnt - lows, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule